// File: doc/BRIEF.md
# Precise Trap Commit Controller

This block makes exceptions precise in a five-stage in-order pipeline that advances every cycle. A fault that the decode or execute stage finds does not act where it is found. A short code is attached to the instruction and moves down the pipeline with it. The trap is resolved only in the memory stage, which is the commit point. There the carried code is combined with a late data address fault and with the external interrupt line. If the instruction at commit has to trap, the block does four things. It asserts kill on every stage in that same cycle, so that neither the trapping instruction nor any younger one changes architectural state. It records the trap code and the trapping PC. In the following cycle it sends fetch to a fixed handler address.

The block keeps its own valid, PC and code registers for the decode, execute and memory stages. Fetch hands it each instruction's PC and valid bit. Detection logic elsewhere raises a per-stage flag that applies to the instruction currently in that stage. The commit port reports which instruction is allowed to write back.

Top module: `exc_commit_ctrl`

## Requirements
- R1: A valid instruction presented at the fetch input, with no fault and no interrupt, appears at commit (commit_valid_o high, commit_pc_o equal to its PC) exactly three cycles later, and the instructions commit in fetch order.
- R2: Each instruction keeps the first fault that is detected for it. An illegal opcode flagged in decode outranks an overflow flagged in execute, which in turn outranks a data address fault flagged in memory.
- R3: If irq_i is high while a valid instruction is at commit, a trap is taken with code 1, whatever faults that instruction carries. The trap PC is the PC of that instruction.
- R4: If irq_i is high while the commit stage holds no valid instruction, no trap is taken. The kill lines stay low and the trap code and trap PC stay unchanged.
- R5: In the cycle a trap is taken, all four kill lines (fetch, decode, execute, memory) are high and commit_valid_o is low, so the trapping instruction does not write back.
- R6: In the cycle after a trap, cause_o shows the trap code and epc_o shows the trapping PC. The codes are 0 none, 1 interrupt, 2 illegal opcode, 3 overflow and 4 data address fault. Both values hold until the next trap, and both are 0 after reset.
- R7: redirect_valid_o is high for exactly the one cycle after a trap, with redirect_pc_o equal to the HANDLER_PC parameter (0x80 by default).
- R8: The instructions in decode and execute, and the one presented at fetch in the trap cycle, are discarded. None of them ever commits, and flags raised for them have no effect.
- R9: A fault flag raised for a stage that holds no valid instruction is ignored: no trap follows from it.
- R10: While reset is held and just after it, every kill line, redirect_valid_o and commit_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | An instruction is leaving fetch this cycle |
| fetch_pc_i | input | PC_W | PC of that instruction |
| dec_illegal_i | input | 1 | Instruction in decode has an illegal opcode |
| exe_ovf_i | input | 1 | Instruction in execute overflowed |
| mem_addr_fault_i | input | 1 | Instruction in memory has an illegal data address |
| irq_i | input | 1 | External interrupt request, level |
| kill_f_o | output | 1 | Squash the instruction leaving fetch |
| kill_d_o | output | 1 | Squash decode |
| kill_e_o | output | 1 | Squash execute |
| kill_m_o | output | 1 | Squash the memory (commit) stage |
| commit_valid_o | output | 1 | Instruction at commit may write back |
| commit_pc_o | output | PC_W | PC of the instruction at commit |
| redirect_valid_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | PC_W | Handler address |
| epc_o | output | PC_W | PC of the last trapping instruction |
| cause_o | output | 3 | Code of the last trap |

## Verification
The assertions assume that the pipeline never stalls. Every instruction therefore moves one stage per cycle, and each fault flag belongs to whatever the block holds in that stage during that cycle. They also assume that irq_i is a level that stays high until it is served. The directed scenarios drive every input half a cycle away from the clock edge and time each flag to the cycle in which the targeted instruction sits in the matching stage. They also raise flags on purpose against empty or squashed stages, to show that such flags are dropped.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int N_STG = 3;   // decode, execute, memory (commit)
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_IRQ      = 3'd1,
        CAUSE_ILLEGAL  = 3'd2,
        CAUSE_OVERFLOW = 3'd3,
        CAUSE_ADDR     = 3'd4
    } cause_e;

    // Fault code that a given stage can raise; index 0 is decode.
    function automatic cause_e stage_code(input int idx);
        case (idx)
            0:       return CAUSE_ILLEGAL;
            1:       return CAUSE_OVERFLOW;
            default: return CAUSE_ADDR;
        endcase
    endfunction

    // Keep the oldest fault: a carried code is never replaced.
    function automatic cause_e merge_exc(input cause_e carried,
                                         input logic   raise,
                                         input cause_e code);
        if (carried != CAUSE_NONE) return carried;
        if (raise)                 return code;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/ecc_stage.sv
module ecc_stage import ecc_pkg::*; #(
    parameter int     PC_W       = 32,
    parameter cause_e RAISE_CODE = CAUSE_NONE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush_i,
    input  logic            in_valid_i,
    input  logic [PC_W-1:0] in_pc_i,
    input  cause_e          in_exc_i,
    input  logic            raise_i,
    output logic            valid_o,
    output logic [PC_W-1:0] pc_o,
    output cause_e          exc_o
);

    logic            valid_q;
    logic [PC_W-1:0] pc_q;
    cause_e          exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pc_q    <= '0;
            exc_q   <= CAUSE_NONE;
        end else begin
            valid_q <= in_valid_i & ~flush_i;
            pc_q    <= in_pc_i;
            exc_q   <= in_exc_i;
        end
    end

    assign valid_o = valid_q;
    assign pc_o    = pc_q;
    // a flag raised for an empty slot is dropped here
    assign exc_o   = merge_exc(exc_q, raise_i & valid_q, RAISE_CODE);

    // R8: a flushed slot is empty on the next cycle
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !valid_o);

endmodule

// File: rtl/ecc_resolve.sv
module ecc_resolve import ecc_pkg::*; (
    input  logic   m_valid_i,
    input  cause_e m_exc_i,
    input  logic   irq_i,
    output logic   take_o,
    output cause_e code_o
);

    always_comb begin
        if (irq_i) code_o = CAUSE_IRQ;   // interrupt overrides all faults
        else       code_o = m_exc_i;
        take_o = m_valid_i && (code_o != CAUSE_NONE);
    end

    // R3: interrupt with a valid commit instruction is always taken as code 1
    always_comb begin
        if (m_valid_i && irq_i)
            p_irq_taken_r3: assert (take_o && code_o == CAUSE_IRQ);
    end

    // R4: nothing is taken from an empty commit stage
    always_comb begin
        if (!m_valid_i)
            p_empty_no_take_r4: assert (!take_o);
    end

endmodule

// File: rtl/ecc_trap_regs.sv
module ecc_trap_regs import ecc_pkg::*; #(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take_i,
    input  cause_e          code_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [CODE_W-1:0] cause_o,
    output logic [PC_W-1:0] epc_o,
    output logic            redirect_valid_o,
    output logic [PC_W-1:0] redirect_pc_o
);

    cause_e          cause_q;
    logic [PC_W-1:0] epc_q;
    logic            redir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_NONE;
            epc_q   <= '0;
            redir_q <= 1'b0;
        end else begin
            redir_q <= take_i;
            if (take_i) begin
                cause_q <= code_i;
                epc_q   <= pc_i;
            end
        end
    end

    assign cause_o          = cause_q;
    assign epc_o            = epc_q;
    assign redirect_valid_o = redir_q;
    assign redirect_pc_o    = redir_q ? HANDLER_PC : '0;

    // R6: trap records hold between traps
    p_trap_regs_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> ($stable(cause_o) && $stable(epc_o)));

    // R7: redirect is a single-cycle pulse
    p_redirect_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        redirect_valid_o |=> !redirect_valid_o);

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl import ecc_pkg::*; #(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid_i,
    input  logic [PC_W-1:0]   fetch_pc_i,
    input  logic              dec_illegal_i,
    input  logic              exe_ovf_i,
    input  logic              mem_addr_fault_i,
    input  logic              irq_i,
    output logic              kill_f_o,
    output logic              kill_d_o,
    output logic              kill_e_o,
    output logic              kill_m_o,
    output logic              commit_valid_o,
    output logic [PC_W-1:0]   commit_pc_o,
    output logic              redirect_valid_o,
    output logic [PC_W-1:0]   redirect_pc_o,
    output logic [PC_W-1:0]   epc_o,
    output logic [CODE_W-1:0] cause_o
);

    localparam int LAST = N_STG - 1;

    logic [N_STG-1:0] stg_valid;
    logic [PC_W-1:0]  stg_pc  [N_STG];
    cause_e           stg_exc [N_STG];
    logic [N_STG-1:0] raise_vec;
    logic             take;
    cause_e           take_code;

    assign raise_vec = {mem_addr_fault_i, exe_ovf_i, dec_illegal_i};

    for (genvar i = 0; i < N_STG; i++) begin : g_stg
        logic            in_v;
        logic [PC_W-1:0] in_pc;
        cause_e          in_exc;
        if (i == 0) begin : g_head
            assign in_v   = fetch_valid_i;
            assign in_pc  = fetch_pc_i;
            assign in_exc = CAUSE_NONE;
        end else begin : g_body
            assign in_v   = stg_valid[i-1];
            assign in_pc  = stg_pc[i-1];
            assign in_exc = stg_exc[i-1];
        end
        ecc_stage #(
            .PC_W       (PC_W),
            .RAISE_CODE (stage_code(i))
        ) u_stage (
            .clk        (clk),
            .rst        (rst),
            .flush_i    (take),
            .in_valid_i (in_v),
            .in_pc_i    (in_pc),
            .in_exc_i   (in_exc),
            .raise_i    (raise_vec[i]),
            .valid_o    (stg_valid[i]),
            .pc_o       (stg_pc[i]),
            .exc_o      (stg_exc[i])
        );
    end

    ecc_resolve u_resolve (
        .m_valid_i (stg_valid[LAST]),
        .m_exc_i   (stg_exc[LAST]),
        .irq_i     (irq_i),
        .take_o    (take),
        .code_o    (take_code)
    );

    ecc_trap_regs #(
        .PC_W       (PC_W),
        .HANDLER_PC (HANDLER_PC)
    ) u_trap (
        .clk              (clk),
        .rst              (rst),
        .take_i           (take),
        .code_i           (take_code),
        .pc_i             (stg_pc[LAST]),
        .cause_o          (cause_o),
        .epc_o            (epc_o),
        .redirect_valid_o (redirect_valid_o),
        .redirect_pc_o    (redirect_pc_o)
    );

    assign kill_f_o       = take;
    assign kill_d_o       = take;
    assign kill_e_o       = take;
    assign kill_m_o       = take;
    assign commit_valid_o = stg_valid[LAST] & ~take;
    assign commit_pc_o    = stg_pc[LAST];

    // R5: the trapping instruction never writes back, all stages die together
    always_comb begin
        if (kill_m_o)
            p_kill_all_r5: assert (kill_f_o && kill_d_o && kill_e_o && !commit_valid_o);
    end

    // R8: after a trap the pipeline is empty and nothing commits
    p_squash_r8: assert property (@(posedge clk) disable iff (rst)
        kill_m_o |=> (stg_valid == '0) && !commit_valid_o);

    // R6/R7: a trap is always followed by a recorded code and a redirect
    p_trap_recorded_r6: assert property (@(posedge clk) disable iff (rst)
        kill_m_o |=> (redirect_valid_o && cause_o != 3'd0));

endmodule

// File: tb/exc_commit_ctrl_bench.sv
`timescale 1ns/1ps
module exc_commit_ctrl_bench;

    localparam int          PC_W    = 32;
    localparam logic [31:0] HANDLER = 32'h80;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fetch_valid_i = 1'b0;
    logic [PC_W-1:0]   fetch_pc_i = '0;
    logic              dec_illegal_i = 1'b0;
    logic              exe_ovf_i = 1'b0;
    logic              mem_addr_fault_i = 1'b0;
    logic              irq_i = 1'b0;
    logic              kill_f_o, kill_d_o, kill_e_o, kill_m_o;
    logic              commit_valid_o;
    logic [PC_W-1:0]   commit_pc_o;
    logic              redirect_valid_o;
    logic [PC_W-1:0]   redirect_pc_o;
    logic [PC_W-1:0]   epc_o;
    logic [2:0]        cause_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) u_exc_commit_ctrl (
        .clk(clk), .rst(rst),
        .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
        .dec_illegal_i(dec_illegal_i), .exe_ovf_i(exe_ovf_i),
        .mem_addr_fault_i(mem_addr_fault_i), .irq_i(irq_i),
        .kill_f_o(kill_f_o), .kill_d_o(kill_d_o), .kill_e_o(kill_e_o), .kill_m_o(kill_m_o),
        .commit_valid_o(commit_valid_o), .commit_pc_o(commit_pc_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .epc_o(epc_o), .cause_o(cause_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, settle, then caller samples
    task automatic cyc(input logic fv, input logic [31:0] pc, input logic ill,
                       input logic ovf, input logic flt, input logic irq);
        @(negedge clk);
        fetch_valid_i    = fv;
        fetch_pc_i       = pc;
        dec_illegal_i    = ill;
        exe_ovf_i        = ovf;
        mem_addr_fault_i = flt;
        irq_i            = irq;
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic chk_kills(input string req, input logic exp);
        chk(req, "kill_f", kill_f_o, exp);
        chk(req, "kill_d", kill_d_o, exp);
        chk(req, "kill_e", kill_e_o, exp);
        chk(req, "kill_m", kill_m_o, exp);
    endtask

    task automatic t_reset;
        chk_kills("R10", 1'b0);
        chk("R10", "redirect_valid", redirect_valid_o, 0);
        chk("R10", "commit_valid", commit_valid_o, 0);
        chk("R6", "cause after reset", cause_o, 0);
        chk("R6", "epc after reset", epc_o, 0);
    endtask

    task automatic t_flow;   // R1
        idle(3);
        cyc(1, 32'h100, 0, 0, 0, 0);
        cyc(1, 32'h104, 0, 0, 0, 0);
        cyc(1, 32'h108, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R1", "commit_valid #1", commit_valid_o, 1);
        chk("R1", "commit_pc #1", commit_pc_o, 32'h100);
        chk_kills("R1", 1'b0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R1", "commit_pc #2", commit_pc_o, 32'h104);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R1", "commit_valid #3", commit_valid_o, 1);
        chk("R1", "commit_pc #3", commit_pc_o, 32'h108);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R1", "drained", commit_valid_o, 0);
    endtask

    task automatic t_illegal;   // R2 R5 R6 R7 R8 R9
        idle(3);
        cyc(1, 32'h200, 0, 0, 0, 0);
        cyc(1, 32'h204, 1, 0, 0, 0);   // 0x200 in decode: illegal
        cyc(1, 32'h208, 0, 1, 0, 0);   // 0x200 in execute: overflow too
        cyc(1, 32'h20C, 0, 0, 1, 0);   // 0x200 at commit: fault too
        chk_kills("R5", 1'b1);
        chk("R5", "no writeback of trapping inst", commit_valid_o, 0);
        cyc(0, 0, 0, 1, 1, 0);         // flags into empty stages
        chk("R2", "illegal outranks later faults", cause_o, 2);
        chk("R6", "epc", epc_o, 32'h200);
        chk("R7", "redirect_valid", redirect_valid_o, 1);
        chk("R7", "redirect_pc", redirect_pc_o, HANDLER);
        chk_kills("R9", 1'b0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R7", "redirect one cycle", redirect_valid_o, 0);
        chk("R8", "0x204 discarded", commit_valid_o, 0);
        chk("R6", "cause holds", cause_o, 2);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R8", "0x208 discarded", commit_valid_o, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R8", "0x20C fetched in trap cycle discarded", commit_valid_o, 0);
        chk_kills("R8", 1'b0);
    endtask

    task automatic t_ovf_vs_fault;   // R2
        idle(3);
        cyc(1, 32'h300, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R2", "kill on overflow", kill_m_o, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R2", "overflow outranks address fault", cause_o, 3);
        chk("R6", "epc overflow", epc_o, 32'h300);
    endtask

    task automatic t_fault;   // R6
        idle(3);
        cyc(1, 32'h400, 0, 0, 0, 0);
        idle(2);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R5", "kill on address fault", kill_d_o, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R6", "address fault code", cause_o, 4);
        chk("R6", "epc fault", epc_o, 32'h400);
    endtask

    task automatic t_irq_empty;   // R4 then R3
        idle(3);
        for (int k = 0; k < 3; k++) begin
            cyc(k == 0, 32'h600, 0, 0, 0, 1);
            chk_kills("R4", 1'b0);
        end
        chk("R4", "cause unchanged", cause_o, 4);
        chk("R4", "epc unchanged", epc_o, 32'h400);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R3", "held irq taken when inst commits", kill_m_o, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R3", "irq code", cause_o, 1);
        chk("R3", "irq epc", epc_o, 32'h600);
    endtask

    task automatic t_irq_override;   // R3
        idle(3);
        cyc(1, 32'h500, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R3", "kill", kill_m_o, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R3", "irq overrides illegal", cause_o, 1);
        chk("R3", "epc is commit pc", epc_o, 32'h500);
        chk("R7", "redirect_pc", redirect_pc_o, HANDLER);
    endtask

    task automatic t_empty_flags;   // R9
        idle(3);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 32'h700, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk_kills("R9", 1'b0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R9", "clean inst commits", commit_valid_o, 1);
        chk("R9", "clean inst pc", commit_pc_o, 32'h700);
        chk("R9", "cause untouched", cause_o, 1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_flow();
        t_illegal();
        t_ovf_vs_fault();
        t_fault();
        t_irq_empty();
        t_irq_override();
        t_empty_flags();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule